// File: doc/BRIEF.md
# PRBS Pattern Generator with Error Injection

The block feeds a serializer with one 20-bit parallel word per transmit clock. After a reset it first sends a fixed run of alignment words. A remote checker uses them to find the transmitter and to lock its word boundary before it starts checking data. Once this run ends, the block sends a pseudo-random bit sequence. The polynomial comes from a 4-bit pattern select, which the block samples only when it comes out of reset.

A level-sensitive error request is turned into a single-cycle pulse on its rising edge. Each pulse inverts bit 0 of the next word sent. The LFSR state does not change, so the stream after the injected error stays on sequence. This lets an operator drive a bit error into the far-end checker deliberately, one error per press.

Top module: `prbs_err_gen`

## Requirements
- R1: While rst_ni is low, data_o is 0. After release, the first 16 words on data_o are the alignment word 20'h3EB05, unless an injection falls on one of them.
- R2: After the alignment words, data_o carries the PRBS serial stream 20 bits per clock, with data_o[19] the earliest bit. The generator restarts from a history of all ones each time the alignment run starts.
- R3: Pattern code 0 selects x[k]=x[k-7]^x[k-6], code 1 selects x[k-15]^x[k-14], code 2 selects x[k-23]^x[k-18], and code 3 selects x[k-31]^x[k-28].
- R4: Only pattern_sel_i[1:0] is decoded. Codes 4 to 15 select the same pattern as their two low bits.
- R5: pattern_sel_i is sampled on the first clock edge after rst_ni rises and on every edge with srst_i high. Changes at any other time have no effect on data_o until the next such sample.
- R6: On a clock edge where err_insert_i is high and was low at the previous edge, bit 0 of the word registered at that edge is inverted. A held-high level injects exactly one error.
- R7: An injected error does not disturb the sequence. The words that follow match the uninjected stream.
- R8: On a clock edge with srst_i high, data_o becomes 0. The following edges restart the 16 alignment words and then the PRBS from its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous restart, high active |
| pattern_sel_i | input | 4 | Pattern code, sampled at reset |
| err_insert_i | input | 1 | Level error request, rising edge injects |
| data_o | output | 20 | Parallel word to the serializer |

## Verification
The assertions assume that err_insert_i and srst_i are synchronous to clk_i and change only between edges. They also assume that pattern_sel_i is stable around each edge at which it is sampled. The stimulus drives every input on the falling edge, so these assumptions always hold. Error requests are held for several cycles and also dropped for a single cycle, covering both single-pulse and back-to-back edge cases. Restarts are issued both during the alignment run and during the PRBS stream.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int LFSR_W  = 31;
  localparam int NUM_PAT = 4;

  typedef enum logic [1:0] {PAT_P7, PAT_P15, PAT_P23, PAT_P31} pat_e;

  function automatic int tap_len(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int tap_mid(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/prbs_err_edge.sv
module prbs_err_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  output logic pulse_o
);
  logic err_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_d <= 1'b0;
    else         err_d <= err_i;
  end

  assign pulse_o = err_i & ~err_d;

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/prbs_step.sv
module prbs_step #(
  parameter int N  = 7,
  parameter int M  = 6,
  parameter int W  = 20,
  parameter int SW = 31
) (
  input  logic [SW-1:0] st_i,
  output logic [SW-1:0] st_o,
  output logic [W-1:0]  word_o
);
  logic [SW-1:0] s;
  logic [W-1:0]  w;
  logic          b;

  // unrolled W-step shift; s[0] holds the newest bit
  always_comb begin
    s = st_i;
    w = '0;
    b = 1'b0;
    for (int j = 0; j < W; j++) begin
      b        = s[N-1] ^ s[M-1];
      w[W-1-j] = b;
      s        = {s[SW-2:0], b};
    end
    st_o   = s;
    word_o = w;
  end
endmodule

// File: rtl/prbs_step_bank.sv
module prbs_step_bank
  import prbs_gen_pkg::*;
#(
  parameter int W = 20
) (
  input  pat_e              pat_i,
  input  logic [LFSR_W-1:0] st_i,
  output logic [LFSR_W-1:0] st_o,
  output logic [W-1:0]      word_o
);
  logic [LFSR_W-1:0] st_a [NUM_PAT];
  logic [W-1:0]      wd_a [NUM_PAT];

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_poly
    prbs_step #(
      .N (tap_len(g)),
      .M (tap_mid(g)),
      .W (W),
      .SW(LFSR_W)
    ) u_step (
      .st_i  (st_i),
      .st_o  (st_a[g]),
      .word_o(wd_a[g])
    );
  end

  assign st_o   = st_a[pat_i];
  assign word_o = wd_a[pat_i];
endmodule

// File: rtl/prbs_preamble_ctl.sv
module prbs_preamble_ctl #(
  parameter int PRE_LEN = 16,
  localparam int CW     = $clog2(PRE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic in_pre_o
);
  logic [CW-1:0] cnt_q;

  assign in_pre_o = (cnt_q < CW'(PRE_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (srst_i)   cnt_q <= '0;
    else if (in_pre_o) cnt_q <= cnt_q + 1'b1;
  end

  p_pre_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PRE_LEN));
  p_pre_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> in_pre_o);
endmodule

// File: rtl/prbs_err_gen.sv
module prbs_err_gen
  import prbs_gen_pkg::*;
#(
  parameter int               W        = 20,
  parameter int               PRE_LEN  = 16,
  parameter logic [W-1:0]     PRE_WORD = 20'h3EB05
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [3:0]   pattern_sel_i,
  input  logic         err_insert_i,
  output logic [W-1:0] data_o
);
  localparam logic [LFSR_W-1:0] SEED = '1;

  pat_e              pat_q;
  logic              fresh_q;
  logic [LFSR_W-1:0] st_q, st_nx;
  logic [W-1:0]      wd_nx, data_q;
  logic              in_pre, pulse;

  prbs_err_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (err_insert_i),
    .pulse_o(pulse)
  );

  prbs_preamble_ctl #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .in_pre_o(in_pre)
  );

  prbs_step_bank #(.W(W)) u_bank (
    .pat_i (pat_q),
    .st_i  (st_q),
    .st_o  (st_nx),
    .word_o(wd_nx)
  );

  // pattern is captured only when leaving a reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q   <= PAT_P7;
      fresh_q <= 1'b1;
    end else if (srst_i || fresh_q) begin
      pat_q   <= pat_e'(pattern_sel_i[1:0]);
      fresh_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEED;
      data_q <= '0;
    end else if (srst_i) begin
      st_q   <= SEED;
      data_q <= '0;
    end else if (in_pre) begin
      data_q <= PRE_WORD ^ W'(pulse);
    end else begin
      st_q   <= st_nx;
      data_q <= wd_nx ^ W'(pulse);
    end
  end

  assign data_o = data_q;

  p_pat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !fresh_q) |=> $stable(pat_q));
  p_srst_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (data_o == '0));
  p_pre_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pre && !srst_i && !err_insert_i) |=> (data_o == PRE_WORD));
  p_state_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  p_seed_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pre && !srst_i) |=> (st_q == SEED));
endmodule

// File: tb/prbs_err_gen_tb_top.sv
module prbs_err_gen_tb_top;
  localparam int CLK_P = 10;
  localparam logic [19:0] PRE = 20'h3EB05;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        srst_i = 1'b0;
  logic [3:0]  pattern_sel_i = '0;
  logic        err_insert_i = 1'b0;
  logic [19:0] data_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit          hist[$];
  int          m_cnt;
  int          m_pat;
  bit          m_fresh;
  bit          m_err_d;
  logic [19:0] exp_w;

  prbs_err_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i),
    .pattern_sel_i(pattern_sel_i), .err_insert_i(err_insert_i), .data_o(data_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic int len_of(int p);
    return (p == 0) ? 7 : (p == 1) ? 15 : (p == 2) ? 23 : 31;
  endfunction
  function automatic int mid_of(int p);
    return (p == 0) ? 6 : (p == 1) ? 14 : (p == 2) ? 18 : 28;
  endfunction

  task automatic seed_hist();
    hist.delete();
    for (int i = 0; i < 31; i++) hist.push_back(1'b1);
  endtask

  task automatic next_word(output logic [19:0] w);
    int n = len_of(m_pat);
    int m = mid_of(m_pat);
    for (int j = 0; j < 20; j++) begin
      bit b = hist[hist.size()-n] ^ hist[hist.size()-m];
      hist.push_back(b);
      void'(hist.pop_front());
      w[19-j] = b;
    end
  endtask

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data_o=%05h expected %05h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic step(bit srst, bit err, logic [3:0] sel, string tag);
    bit pulse;
    srst_i = srst; err_insert_i = err; pattern_sel_i = sel;
    if (srst) begin
      exp_w = '0; m_cnt = 0; seed_hist(); m_pat = int'(sel[1:0]); m_fresh = 0;
      m_err_d = err;
    end else begin
      pulse = err && !m_err_d;
      m_err_d = err;
      if (m_fresh) begin m_pat = int'(sel[1:0]); m_fresh = 0; end
      if (m_cnt < 16) begin exp_w = PRE; m_cnt++; end
      else next_word(exp_w);
      exp_w[0] = exp_w[0] ^ pulse;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, data_o, exp_w);
  endtask

  task automatic async_reset(logic [3:0] sel);
    @(negedge clk_i);
    rst_ni = 1'b0; pattern_sel_i = sel;
    m_cnt = 0; seed_hist(); m_fresh = 1; m_err_d = 0; m_pat = 0;
    #1 check("R1", data_o, 20'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(int n, bit err, logic [3:0] sel, string tag);
    for (int i = 0; i < n; i++) step(1'b0, err, sel, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    seed_hist();
    @(negedge clk_i);
    check("R1", data_o, 20'h0);
    async_reset(4'd0);
    run(16, 0, 4'd0, "R1");
    run(40, 0, 4'd0, "R2");
    // R5: select changes mid-run are ignored
    run(20, 0, 4'd3, "R5");
    // R8 restart into PRBS15
    step(1'b1, 0, 4'd1, "R8");
    run(8, 0, 4'd1, "R8");
    step(1'b1, 0, 4'd1, "R8");    // restart inside the preamble
    run(16, 0, 4'd2, "R8");
    run(30, 0, 4'd2, "R3");
    // PRBS23 with injection
    step(1'b1, 0, 4'd2, "R3");
    run(20, 0, 4'd2, "R3");
    run(6, 1, 4'd2, "R6");         // held high: one error only
    run(10, 0, 4'd2, "R7");
    step(1'b0, 1, 4'd2, "R6");
    step(1'b0, 0, 4'd2, "R6");
    step(1'b0, 1, 4'd2, "R6");    // second edge after one low cycle
    run(10, 0, 4'd2, "R7");
    // injection inside preamble
    step(1'b1, 0, 4'd3, "R8");
    run(3, 0, 4'd3, "R1");
    run(2, 1, 4'd3, "R6");
    run(40, 0, 4'd3, "R3");
    // R4: code 6 aliases code 2, code 13 aliases code 1
    step(1'b1, 0, 4'd6, "R4");
    run(50, 0, 4'd6, "R4");
    step(1'b1, 0, 4'd13, "R4");
    run(50, 0, 4'd13, "R4");
    // R5: async reset samples select on first edge
    async_reset(4'd3);
    run(16, 0, 4'd3, "R1");
    run(40, 0, 4'd0, "R5");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule